// File: doc/BRIEF.md
# Hybrid-encoded early-reset full adder

This block is a single full-adder cell for delay-insensitive data using a four-phase return-to-zero protocol. The two operand bits arrive on dual-rail pairs and a small front-end encoder merges them, through four two-input C-elements, into one 1-of-4 operand code. The adder core combines that code with a dual-rail carry-in to produce a dual-rail sum and a dual-rail carry-out. Outputs rise monotonically during the valid phase. In the return-to-zero phase both output pairs fall to the spacer as soon as the operand code clears, with no wait for the carry-in to clear.

For RTL simulation each C-element is modelled as a hold-state gate: its output is the majority of its two inputs and a stored copy of its last output, and a sampling clock refreshes that copy. Every input level must therefore stay stable across at least one rising edge of `clk` before the next input changes. The rails follow the handshake protocol directly. There is no valid/ready pair, because validity is carried by the codes themselves and back-pressure is applied by the environment, which withholds the next code until the outputs have been seen. A (1,1) rail pair on any input is outside the contract and has no defined response.

Top module: `hyb_fa`

## Requirements
- R1: While `rst_n` is low and for as long as all inputs stay at the spacer after reset, both output pairs read (0,0).
- R2: Each dual-rail pair is written as (true rail, false rail). (1,0) is logic 1, (0,1) is logic 0 and (0,0) is the spacer. The true rails are `a_t`, `b_t`, `cin_t`, `sum_t` and `cout_t`.
- R3: With both operands and the carry-in valid, the sum pair encodes A xor B xor Cin.
- R4: With both operands and the carry-in valid, the carry-out pair encodes the majority of A, B and Cin.
- R5: At no time are both rails of the sum pair high, and at no time are both rails of the carry-out pair high.
- R6: While one operand is valid and the other is still at the spacer, both output pairs stay at the spacer.
- R7: When A equals B and the carry-in is at the spacer, the carry-out is already valid and equals A, and the sum stays at the spacer until the carry-in becomes valid.
- R8: When A differs from B, the carry-out stays at the spacer until the carry-in is valid, and then it copies the carry-in.
- R9: Once both operands are at the spacer, both output pairs read (0,0), even while the carry-in is still valid.
- R10: If the carry-in returns to the spacer while both operands stay valid, the sum keeps its value. The carry-out keeps its value when A equals B and returns to the spacer when A differs from B.
- R11: If one operand returns to the spacer while the other operand and the carry-in stay valid, both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock that refreshes the C-element state copies |
| rst_n | input | 1 | Active-low asynchronous reset; clears all C-element state |
| a_t | input | 1 | Operand A, true rail |
| a_f | input | 1 | Operand A, false rail |
| b_t | input | 1 | Operand B, true rail |
| b_f | input | 1 | Operand B, false rail |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| sum_t | output | 1 | Sum, true rail |
| sum_f | output | 1 | Sum, false rail |
| cout_t | output | 1 | Carry-out, true rail |
| cout_f | output | 1 | Carry-out, false rail |

## Verification
The bench takes each of the eight input combinations through a fixed phase order: operand A, then operand B, then the carry-in, a carry-in withdrawal and its return, then the two operands withdrawn one at a time. It checks the outputs after every phase. A cell whose carry waits for the carry-in in generate or kill mode would fail the early-set check. A cell whose sum bypasses its C-element would lose the sum when the carry-in clears first. An encoder without C-elements would drop the outputs when only one operand clears. A cell that waited for the carry-in spacer before resetting would show valid outputs after both operands had cleared.

// File: rtl/hyb_fa_pkg.sv
package hyb_fa_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned IDX_KILL = 0;
  localparam int unsigned IDX_PROP_LO = 1;
  localparam int unsigned IDX_PROP_HI = 2;
  localparam int unsigned IDX_GEN = 3;

  typedef logic [CODE_W-1:0] quad_t;

  typedef struct packed {
    logic t;
    logic f;
  } rail_t;
endpackage

// File: rtl/hyb_celem.sv
module hyb_celem #(
  parameter int unsigned LANES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] x,
  input  logic [LANES-1:0] y,
  output logic [LANES-1:0] z
);
  logic [LANES-1:0] keep_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign z[i] = (x[i] & y[i]) | (keep_q[i] & (x[i] | y[i]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) keep_q[i] <= 1'b0;
      else        keep_q[i] <= z[i];
    end

    // R10 R11: a lane whose inputs disagree holds its previous output
    celem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((x[i] != y[i]) && $past(x[i] != y[i])) |-> (z[i] == $past(z[i])));

    // R9: a lane with both inputs low is low
    celem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!x[i] && !y[i]) |-> !z[i]);
  end
endmodule

// File: rtl/hyb_enc.sv
module hyb_enc
  import hyb_fa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  rail_t opa,
  input  rail_t opb,
  output quad_t code
);
  quad_t lhs, rhs;

  always_comb begin
    lhs[IDX_KILL]    = opa.f;  rhs[IDX_KILL]    = opb.f;
    lhs[IDX_PROP_LO] = opa.f;  rhs[IDX_PROP_LO] = opb.t;
    lhs[IDX_PROP_HI] = opa.t;  rhs[IDX_PROP_HI] = opb.f;
    lhs[IDX_GEN]     = opa.t;  rhs[IDX_GEN]     = opb.t;
  end

  hyb_celem #(.LANES(CODE_W)) u_pair (
    .clk  (clk),
    .rst_n(rst_n),
    .x    (lhs),
    .y    (rhs),
    .z    (code)
  );

  // R6: one operand still at the spacer never raises a fresh code line
  enc_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((!opa.t && !opa.f) || (!opb.t && !opb.f)) && ($past(code) == '0)) |-> (code == '0));
endmodule

// File: rtl/hyb_core.sv
module hyb_core
  import hyb_fa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  quad_t code,
  input  rail_t cin,
  output rail_t sum,
  output rail_t cout
);
  logic kg, prop, any;
  logic pre_t, pre_f;
  logic [1:0] sum_pair;

  always_comb begin
    kg    = code[IDX_KILL] | code[IDX_GEN];
    prop  = code[IDX_PROP_LO] | code[IDX_PROP_HI];
    any   = kg | prop;
    pre_t = (prop & cin.f) | (kg & cin.t);
    pre_f = (prop & cin.t) | (kg & cin.f);
    cout.t = (prop & cin.t) | code[IDX_GEN];
    cout.f = (prop & cin.f) | code[IDX_KILL];
  end

  hyb_celem #(.LANES(2)) u_sum (
    .clk  (clk),
    .rst_n(rst_n),
    .x    ({pre_t, pre_f}),
    .y    ({any, any}),
    .z    (sum_pair)
  );

  assign sum.t = sum_pair[1];
  assign sum.f = sum_pair[0];

  // R5
  sum_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sum.t, sum.f}));
  // R5
  cout_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cout.t, cout.f}));
  // R7
  gen_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code[IDX_GEN] |-> (cout.t && !cout.f));
  // R7
  kill_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code[IDX_KILL] |-> (cout.f && !cout.t));
  // R9
  early_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> (!sum.t && !sum.f && !cout.t && !cout.f));
  // R8
  prop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((code[IDX_PROP_LO] || code[IDX_PROP_HI]) && !cin.t && !cin.f) |-> (!cout.t && !cout.f));
endmodule

// File: rtl/hyb_fa.sv
module hyb_fa
  import hyb_fa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_t,
  input  logic a_f,
  input  logic b_t,
  input  logic b_f,
  input  logic cin_t,
  input  logic cin_f,
  output logic sum_t,
  output logic sum_f,
  output logic cout_t,
  output logic cout_f
);
  quad_t code;
  rail_t opa, opb, cin, sum, cout;

  assign opa = '{t: a_t, f: a_f};
  assign opb = '{t: b_t, f: b_f};
  assign cin = '{t: cin_t, f: cin_f};

  hyb_enc u_enc (
    .clk  (clk),
    .rst_n(rst_n),
    .opa  (opa),
    .opb  (opb),
    .code (code)
  );

  hyb_core u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .code (code),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  assign sum_t  = sum.t;
  assign sum_f  = sum.f;
  assign cout_t = cout.t;
  assign cout_f = cout.f;

  // R9: both operand pairs at the spacer force spacer outputs
  top_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_t && !a_f && !b_t && !b_f) |-> (!sum_t && !sum_f && !cout_t && !cout_f));
endmodule

// File: tb/tb_hyb_fa.sv
module tb_hyb_fa;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_t = 0, a_f = 0, b_t = 0, b_f = 0, cin_t = 0, cin_f = 0;
  logic sum_t, sum_f, cout_t, cout_f;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hyb_fa dut (
    .clk(clk), .rst_n(rst_n),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .cin_t(cin_t), .cin_f(cin_f),
    .sum_t(sum_t), .sum_f(sum_f), .cout_t(cout_t), .cout_f(cout_f)
  );

  // {a, b, cin, expected sum, expected carry}
  localparam logic [4:0] VEC [8] = '{
    5'b000_0_0, 5'b001_1_0, 5'b010_1_0, 5'b011_0_1,
    5'b100_1_0, 5'b101_0_1, 5'b110_0_1, 5'b111_1_1
  };

  function automatic logic [1:0] dr(input logic v);
    return v ? 2'b10 : 2'b01;
  endfunction

  task automatic settle();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [1:0] es, input logic [1:0] ec);
    chk({tag, " sum"}, {sum_t, sum_f}, es);
    chk({tag, " cout"}, {cout_t, cout_f}, ec);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] sp;
    sp = 2'b00;
    settle();
    // R1: outputs at spacer during reset
    chk_out("R1 in reset", sp, sp);
    rst_n = 1'b1;
    settle();
    chk_out("R1 after reset", sp, sp);

    for (int i = 0; i < 8; i++) begin
      logic va, vb, vc, es, ec;
      logic [1:0] early_c;
      {va, vb, vc, es, ec} = VEC[i];
      early_c = (va == vb) ? dr(va) : sp;

      {a_t, a_f} = dr(va);
      settle();
      chk_out("R6 only A valid", sp, sp);

      {b_t, b_f} = dr(vb);
      settle();
      // R7 sum waits for carry-in; R7/R8 carry early only when A equals B
      chk({"R7 sum waits"}, {sum_t, sum_f}, sp);
      chk({(va == vb) ? "R7 early carry" : "R8 carry waits"}, {cout_t, cout_f}, early_c);

      {cin_t, cin_f} = dr(vc);
      settle();
      // R2 R3 R4: decoded values with (t,f) encoding
      chk("R3 sum value", {sum_t, sum_f}, dr(es));
      chk((va == vb) ? "R4 carry value" : "R8 carry copies cin", {cout_t, cout_f}, dr(ec));
      chk("R5 sum one-hot", {1'b0, sum_t & sum_f}, 2'b00);
      chk("R5 cout one-hot", {1'b0, cout_t & cout_f}, 2'b00);

      {cin_t, cin_f} = sp;
      settle();
      chk("R10 sum holds", {sum_t, sum_f}, dr(es));
      chk("R10 cout after cin spacer", {cout_t, cout_f}, early_c);

      {cin_t, cin_f} = dr(vc);
      settle();
      chk_out("R4 cin restored", dr(es), dr(ec));

      {a_t, a_f} = sp;
      settle();
      chk_out("R11 A spacer only", dr(es), dr(ec));

      {b_t, b_f} = sp;
      settle();
      chk_out("R9 early reset", sp, sp);

      {cin_t, cin_f} = sp;
      settle();
      chk_out("R9 all spacer", sp, sp);
    end

    // R11: B withdrawn first, A kept valid (generate case)
    {a_t, a_f} = 2'b10; {b_t, b_f} = 2'b10; {cin_t, cin_f} = 2'b01;
    settle();
    chk_out("R4 gen with cin 0", 2'b01, 2'b10);
    {b_t, b_f} = sp;
    settle();
    chk_out("R11 B spacer only", 2'b01, 2'b10);
    {a_t, a_f} = sp;
    settle();
    chk_out("R9 reset with cin held", sp, sp);
    {cin_t, cin_f} = sp;
    settle();

    // R6: B valid alone with carry-in valid
    {b_t, b_f} = 2'b01; {cin_t, cin_f} = 2'b10;
    settle();
    chk_out("R6 only B and cin valid", sp, sp);
    {b_t, b_f} = sp; {cin_t, cin_f} = sp;
    settle();
    chk_out("R1 idle spacer", sp, sp);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule